// File: doc/BRIEF.md
# SDRAM Initialization Command Sequencer

This block lets firmware put an SDRAM device through its power-up sequence one command at a time. Firmware uses a small control register on a CPU register bus. It sets the controller enable bit and one or more arm bits, one each for precharge-all, auto-refresh and mode-register-set. It then makes a write of any data into the SDRAM address window. That write fires exactly one command on the SDRAM command pins. The command is the highest-priority armed one, and its arm bit then clears by itself.

For a mode-register-set, the data of the dummy write is ignored. The mode value comes from the CPU address bits of the write, which map onto the SDRAM bank and address lines. The block records whether the CAS latency encoded in that address agrees with a CAS latency setting from a separate configuration input. It also keeps a read-only done flag. The flag rises after a mode-register-set that follows at least one precharge-all and two auto-refreshes. Firmware checks the flag before it makes ordinary accesses. Every accepted window write is followed by a fixed recovery time, during which the memory port reports not-ready.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the register reads 0, `mem_ready` is 1, `cas_err` is 0, and the SDRAM pins idle with CS#, RAS#, CAS# and WE# all 1 and BA and A all 0.
- R2: Register bit 4 is controller enable, bit 2 arms mode-register-set, bit 1 arms precharge-all and bit 0 arms auto-refresh. All four are read/write. Bit 3 is the done flag and is read-only. Bits 31..5 always read 0.
- R3: A window write accepted while enabled with precharge-all armed drives CS#,RAS#,CAS#,WE# = 0,0,1,0 for exactly the one cycle after acceptance. In that cycle A10 is 1 and all other A and BA bits are 0.
- R4: An accepted write that fires an auto-refresh drives CS#,RAS#,CAS#,WE# = 0,0,0,1 for one cycle, with A and BA all 0.
- R5: An accepted write that fires a mode-register-set drives CS#,RAS#,CAS#,WE# = 0,0,0,0 for one cycle. In that cycle BA1 equals CPU address bit 15, BA0 equals bit 14, and A[n] equals CPU address bit n+1 for n = 0..12.
- R6: When several arm bits are set, precharge-all fires first, then auto-refresh, then mode-register-set. Only the arm bit of the fired command clears.
- R7: A window write is still accepted while the enable bit is 0 or while no arm bit is set, but no command is issued and the arm bits keep their values.
- R8: After each accepted window write, `mem_ready` is 0 for exactly two cycles. A write held during those cycles is not accepted until `mem_ready` returns to 1.
- R9: The done flag reads 1 from the second cycle after an accepted mode-register-set write. This requires that at least one precharge-all and two auto-refreshes were issued before it. Once set, the flag stays 1 until reset.
- R10: A mode-register-set issued before the prerequisites of R9 are met leaves the done flag at 0. A later mode-register-set issued once they are met sets it.
- R11: `cas_err`, valid in the command cycle of each mode-register-set, is 1 when CPU address bits 7..5 (mode bits A[6:4]) differ from `cfg_cas_lat` and 0 when they match. It holds its value between mode-register-set commands.
- R12: Each arming produces one command only. A second window write without re-arming issues no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register read value |
| mem_wr | input | 1 | Write request into the SDRAM window |
| mem_addr | input | 15 | CPU byte address bits 15..1 of the window write |
| mem_ready | output | 1 | Window write accepted when high together with mem_wr |
| cfg_cas_lat | input | 3 | Configured CAS latency for the mismatch check |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | 2 | SDRAM bank address |
| sd_a | output | 13 | SDRAM address lines |
| cas_err | output | 1 | CAS latency mismatch of the last mode-register-set |

## Verification
The firing path is tested with single arm bits, with all three arm bits set together while a write request is held through the recovery window, and with writes made while the block is disabled or unarmed. Together these separate the priority order, the self-clearing of arm bits, the gating by enable, and the acceptance gating by `mem_ready`. Mode-register-set writes use a dense address pattern with a non-zero bank field and a second address whose CAS field matches the configuration. This exposes swapped bank bits, an address shifted by one bit, and an inverted mismatch flag. The two permitted command orderings are run from reset to show that the done flag depends on the prerequisites as well as on the mode-register-set itself.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_PALL = 2'd1,
      CMD_REF  = 2'd2,
      CMD_MRS  = 2'd3
   } init_cmd_e;

   // control register bit positions (firmware-visible)
   localparam int unsigned BIT_ARM_REF  = 0;
   localparam int unsigned BIT_ARM_PALL = 1;
   localparam int unsigned BIT_ARM_MRS  = 2;
   localparam int unsigned BIT_DONE     = 3;
   localparam int unsigned BIT_ENABLE   = 4;
   localparam int unsigned CTRL_BITS    = 5;

endpackage

// File: rtl/sdinit_ctrl_reg.sv
`timescale 1ns/1ps
module sdinit_ctrl_reg
   import sdram_init_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              clr_pall,
   input  logic              clr_ref,
   input  logic              clr_mrs,
   input  logic              done,
   output logic              enable,
   output logic              arm_pall,
   output logic              arm_ref,
   output logic              arm_mrs,
   output logic [DATA_W-1:0] reg_rdata
);

   if (DATA_W < CTRL_BITS) begin : g_bad_width
      $error("sdinit_ctrl_reg: DATA_W too small for control bits");
   end

   // reserved and read-only write bits are intentionally dropped
   wire unused_wbits = ^{reg_wdata[DATA_W-1:CTRL_BITS], reg_wdata[BIT_DONE]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable   <= 1'b0;
         arm_pall <= 1'b0;
         arm_ref  <= 1'b0;
         arm_mrs  <= 1'b0;
      end else if (reg_we) begin
         enable   <= reg_wdata[BIT_ENABLE];
         arm_pall <= reg_wdata[BIT_ARM_PALL];
         arm_ref  <= reg_wdata[BIT_ARM_REF];
         arm_mrs  <= reg_wdata[BIT_ARM_MRS];
      end else begin
         if (clr_pall) arm_pall <= 1'b0;
         if (clr_ref)  arm_ref  <= 1'b0;
         if (clr_mrs)  arm_mrs  <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata               = '0;
      reg_rdata[BIT_ENABLE]   = enable;
      reg_rdata[BIT_DONE]     = done;
      reg_rdata[BIT_ARM_MRS]  = arm_mrs;
      reg_rdata[BIT_ARM_PALL] = arm_pall;
      reg_rdata[BIT_ARM_REF]  = arm_ref;
   end

   // R6
   arm_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pall && !reg_we) |=> !arm_pall);

endmodule

// File: rtl/sdinit_cmd_pick.sv
`timescale 1ns/1ps
module sdinit_cmd_pick
   import sdram_init_pkg::*;
(
   input  logic      enable,
   input  logic      arm_pall,
   input  logic      arm_ref,
   input  logic      arm_mrs,
   output init_cmd_e cmd
);

   always_comb begin
      cmd = CMD_NONE;
      if (enable) begin
         if (arm_pall)     cmd = CMD_PALL;
         else if (arm_ref) cmd = CMD_REF;
         else if (arm_mrs) cmd = CMD_MRS;
      end
   end

endmodule

// File: rtl/sdinit_pin_drv.sv
`timescale 1ns/1ps
module sdinit_pin_drv
   import sdram_init_pkg::*;
#(
   parameter int unsigned ROW_BITS  = 13,
   parameter int unsigned BANK_BITS = 2,
   parameter int unsigned AP_BIT    = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire,
   input  init_cmd_e            cmd,
   input  logic [BANK_BITS-1:0] mode_ba,
   input  logic [ROW_BITS-1:0]  mode_a,
   output logic                 cs_n,
   output logic                 ras_n,
   output logic                 cas_n,
   output logic                 we_n,
   output logic [BANK_BITS-1:0] ba,
   output logic [ROW_BITS-1:0]  a
);

   if (AP_BIT >= ROW_BITS) begin : g_bad_ap
      $error("sdinit_pin_drv: AP_BIT outside address lines");
   end

   localparam logic [ROW_BITS-1:0] AP_MASK = ROW_BITS'(1) << AP_BIT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
         ba <= '0;
         a  <= '0;
      end else begin
         {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
         ba <= '0;
         a  <= '0;
         if (fire) begin
            unique case (cmd)
               CMD_PALL: begin
                  {cs_n, ras_n, cas_n, we_n} <= 4'b0010;
                  a <= AP_MASK;
               end
               CMD_REF: {cs_n, ras_n, cas_n, we_n} <= 4'b0001;
               CMD_MRS: begin
                  {cs_n, ras_n, cas_n, we_n} <= 4'b0000;
                  ba <= mode_ba;
                  a  <= mode_a;
               end
               default: ;
            endcase
         end
      end
   end

   // R3
   cmd_has_row_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> !ras_n);

endmodule

// File: rtl/sdinit_track.sv
`timescale 1ns/1ps
module sdinit_track
   import sdram_init_pkg::*;
#(
   parameter int unsigned CAS_W   = 3,
   parameter int unsigned REF_MIN = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  init_cmd_e        cmd,
   input  logic [CAS_W-1:0] cas_field,
   input  logic [CAS_W-1:0] cfg_cas,
   output logic             done,
   output logic             cas_err
);

   if (REF_MIN < 1) begin : g_bad_ref
      $error("sdinit_track: REF_MIN must be at least 1");
   end

   localparam int unsigned      RCW       = $clog2(REF_MIN + 1);
   localparam logic [RCW-1:0]   REF_MIN_V = RCW'(REF_MIN);

   logic           pall_seen;
   logic [RCW-1:0] ref_cnt;
   logic           mrs_ok;
   logic           mrs_fire;

   assign mrs_fire = fire && (cmd == CMD_MRS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pall_seen <= 1'b0;
         ref_cnt   <= '0;
         mrs_ok    <= 1'b0;
         done      <= 1'b0;
         cas_err   <= 1'b0;
      end else begin
         mrs_ok <= mrs_fire && pall_seen && (ref_cnt == REF_MIN_V);
         done   <= done | mrs_ok;
         if (fire && cmd == CMD_PALL) pall_seen <= 1'b1;
         if (fire && cmd == CMD_REF && ref_cnt != REF_MIN_V) ref_cnt <= ref_cnt + 1'b1;
         if (mrs_fire) cas_err <= (cas_field != cfg_cas);
      end
   end

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R11
   cas_err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mrs_fire |=> $stable(cas_err));

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq
   import sdram_init_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ROW_BITS  = 13,
   parameter int unsigned BANK_BITS = 2,
   parameter int unsigned AP_BIT    = 10,
   parameter int unsigned CAS_LSB   = 4,
   parameter int unsigned CAS_W     = 3,
   parameter int unsigned RECOVERY  = 2,
   parameter int unsigned REF_MIN   = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_we,
   input  logic [DATA_W-1:0]             reg_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   input  logic                          mem_wr,
   input  logic [ROW_BITS+BANK_BITS:1]   mem_addr,
   output logic                          mem_ready,
   input  logic [CAS_W-1:0]              cfg_cas_lat,
   output logic                          sd_cs_n,
   output logic                          sd_ras_n,
   output logic                          sd_cas_n,
   output logic                          sd_we_n,
   output logic [BANK_BITS-1:0]          sd_ba,
   output logic [ROW_BITS-1:0]           sd_a,
   output logic                          cas_err
);

   if (CAS_LSB + CAS_W > ROW_BITS) begin : g_bad_cas
      $error("sdram_init_seq: CAS field outside address lines");
   end

   localparam int unsigned BA_LO = ROW_BITS + 1;
   localparam int unsigned BA_HI = ROW_BITS + BANK_BITS;

   logic      enable, arm_pall, arm_ref, arm_mrs, done;
   logic      accept, fire;
   init_cmd_e cmd;

   assign accept = mem_wr && mem_ready;
   assign fire   = accept && (cmd != CMD_NONE);

   sdinit_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_wdata(reg_wdata),
      .clr_pall (fire && cmd == CMD_PALL),
      .clr_ref  (fire && cmd == CMD_REF),
      .clr_mrs  (fire && cmd == CMD_MRS),
      .done     (done),
      .enable   (enable),
      .arm_pall (arm_pall),
      .arm_ref  (arm_ref),
      .arm_mrs  (arm_mrs),
      .reg_rdata(reg_rdata)
   );

   sdinit_cmd_pick u_pick (
      .enable  (enable),
      .arm_pall(arm_pall),
      .arm_ref (arm_ref),
      .arm_mrs (arm_mrs),
      .cmd     (cmd)
   );

   sdinit_pin_drv #(
      .ROW_BITS (ROW_BITS),
      .BANK_BITS(BANK_BITS),
      .AP_BIT   (AP_BIT)
   ) u_pins (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (fire),
      .cmd    (cmd),
      .mode_ba(mem_addr[BA_HI:BA_LO]),
      .mode_a (mem_addr[ROW_BITS:1]),
      .cs_n   (sd_cs_n),
      .ras_n  (sd_ras_n),
      .cas_n  (sd_cas_n),
      .we_n   (sd_we_n),
      .ba     (sd_ba),
      .a      (sd_a)
   );

   sdinit_track #(
      .CAS_W  (CAS_W),
      .REF_MIN(REF_MIN)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .cmd      (cmd),
      .cas_field(mem_addr[CAS_LSB+CAS_W:CAS_LSB+1]),
      .cfg_cas  (cfg_cas_lat),
      .done     (done),
      .cas_err  (cas_err)
   );

   // recovery window after each accepted window write
   if (RECOVERY == 0) begin : g_no_recovery
      assign mem_ready = 1'b1;
   end else begin : g_recovery
      localparam int unsigned            RW    = $clog2(RECOVERY + 1);
      localparam logic [RW-1:0]          REC_V = RW'(RECOVERY);
      logic [RW-1:0] rec_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              rec_cnt <= '0;
         else if (accept)         rec_cnt <= REC_V;
         else if (rec_cnt != '0)  rec_cnt <= rec_cnt - 1'b1;
      end
      assign mem_ready = (rec_cnt == '0);

      // R8
      ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         accept |=> !mem_ready);

      // R3
      cs_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !sd_cs_n |=> sd_cs_n);
   end

   // R7
   cmd_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_cs_n |-> $past(enable));

endmodule

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_wr = 1'b0;
   logic [15:1] mem_addr = '0;
   logic        mem_ready;
   logic [2:0]  cfg_cas_lat = 3'd2;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [12:0] sd_a;
   logic        cas_err;

   int n_run = 0;
   int n_fail = 0;

   // captured by mem_write
   logic [3:0]  c_ctl, c_ctl2;
   logic [1:0]  c_ba;
   logic [12:0] c_a;
   logic        c_err, c_rdy1, c_rdy2, c_rdy3, c_done1, c_done2;

   always #2 clk = ~clk;

   sdram_init_seq dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_ready(mem_ready), .cfg_cas_lat(cfg_cas_lat), .sd_cs_n(sd_cs_n),
      .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_a(sd_a), .cas_err(cas_err)
   );

   function automatic logic [3:0] ctl();
      return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; reg_we = 1'b0; mem_wr = 1'b0; mem_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic reg_write(input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // byte address; bits 15..1 go to the port
   task automatic mem_write(input logic [15:0] addr);
      @(negedge clk);
      while (!mem_ready) @(negedge clk);
      mem_wr = 1'b1; mem_addr = addr[15:1];
      @(negedge clk);
      mem_wr = 1'b0;
      c_ctl = ctl(); c_ba = sd_ba; c_a = sd_a; c_err = cas_err;
      c_rdy1 = mem_ready; c_done1 = reg_rdata[3];
      @(negedge clk);
      c_ctl2 = ctl(); c_rdy2 = mem_ready; c_done2 = reg_rdata[3];
      @(negedge clk);
      c_rdy3 = mem_ready;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "reg", reg_rdata, 32'h0);
      chk("R1", "ctl", ctl(), 4'hF);
      chk("R1", "ba/a", {sd_ba, sd_a}, 0);
      chk("R1", "ready", mem_ready, 1);
      chk("R1", "cas_err", cas_err, 0);
   endtask

   task automatic t_regs();
      do_reset();
      reg_write(32'hFFFF_FFFF);
      chk("R2", "all ones read", reg_rdata, 32'h17);
      reg_write(32'h0000_0008);
      chk("R2", "done not writable", reg_rdata, 32'h0);
      reg_write(32'h0000_0005);
      chk("R2", "partial", reg_rdata, 32'h5);
   endtask

   task automatic t_disabled();
      do_reset();
      reg_write(32'h07);
      mem_write(16'h0000);
      chk("R7", "no cmd when disabled", c_ctl, 4'hF);
      chk("R7", "arms kept", reg_rdata, 32'h07);
      chk("R8", "ready low after ignored write", {c_rdy1, c_rdy2, c_rdy3}, 3'b001);
      reg_write(32'h10);
      mem_write(16'h0000);
      chk("R7", "no cmd when unarmed", c_ctl, 4'hF);
      chk("R7", "reg unchanged", reg_rdata, 32'h10);
   endtask

   task automatic t_pall();
      do_reset();
      reg_write(32'h12);
      mem_write(16'hFFFE);
      chk("R3", "pall ctl", c_ctl, 4'b0010);
      chk("R3", "pall addr", {c_ba, c_a}, 15'h0400);
      chk("R3", "one cycle", c_ctl2, 4'hF);
      chk("R6", "pall arm cleared", reg_rdata, 32'h10);
   endtask

   task automatic t_ref();
      do_reset();
      reg_write(32'h11);
      mem_write(16'hFFFE);
      chk("R4", "ref ctl", c_ctl, 4'b0001);
      chk("R4", "ref addr", {c_ba, c_a}, 0);
      chk("R4", "one cycle", c_ctl2, 4'hF);
      chk("R6", "ref arm cleared", reg_rdata, 32'h10);
   endtask

   task automatic t_mrs_map();
      do_reset();
      cfg_cas_lat = 3'd2;
      reg_write(32'h14);
      mem_write(16'hB5A4);   // bits 7..5 = 5, differs from 2
      chk("R5", "mrs ctl", c_ctl, 4'b0000);
      chk("R5", "mrs ba", c_ba, 2'b10);
      chk("R5", "mrs a", c_a, 13'h1AD2);
      chk("R11", "mismatch flagged", c_err, 1);
      chk("R11", "held after cmd", cas_err, 1);
      reg_write(32'h14);
      mem_write(16'h0442);   // CAS field 2
      chk("R5", "mrs a second", {c_ba, c_a}, 15'h0221);
      chk("R11", "match clears", c_err, 0);
   endtask

   task automatic t_priority_ready();
      do_reset();
      reg_write(32'h17);
      @(negedge clk);
      mem_wr = 1'b1; mem_addr = '0;
      @(negedge clk);
      chk("R6", "pall first", ctl(), 4'b0010);
      chk("R8", "ready low k+1", mem_ready, 0);
      @(negedge clk);
      chk("R8", "ready low k+2", mem_ready, 0);
      chk("R8", "held write not accepted", ctl(), 4'hF);
      @(negedge clk);
      chk("R8", "ready back k+3", mem_ready, 1);
      chk("R8", "still no cmd", ctl(), 4'hF);
      @(negedge clk);
      mem_wr = 1'b0;
      chk("R6", "ref second", ctl(), 4'b0001);
      chk("R6", "mrs still armed", reg_rdata, 32'h14);
      mem_write(16'h0442);
      chk("R6", "mrs third", c_ctl, 4'b0000);
   endtask

   task automatic t_once();
      do_reset();
      reg_write(32'h12);
      mem_write(16'h0000);
      chk("R12", "first fires", c_ctl, 4'b0010);
      mem_write(16'h0000);
      chk("R12", "second silent", c_ctl, 4'hF);
   endtask

   task automatic t_order1();
      do_reset();
      cfg_cas_lat = 3'd2;
      reg_write(32'h12); mem_write(16'h0);
      reg_write(32'h11); mem_write(16'h0);
      reg_write(32'h11); mem_write(16'h0);
      chk("R9", "not done before mrs", reg_rdata[3], 0);
      reg_write(32'h14); mem_write(16'h0442);
      chk("R9", "done low in cmd cycle", c_done1, 0);
      chk("R9", "done next cycle", c_done2, 1);
      reg_write(32'h10);
      mem_write(16'h0);
      chk("R9", "done sticky", reg_rdata, 32'h18);
   endtask

   task automatic t_order2();
      do_reset();
      reg_write(32'h12); mem_write(16'h0);
      reg_write(32'h14); mem_write(16'h0442);
      chk("R10", "mrs issued early", c_ctl, 4'b0000);
      chk("R10", "early mrs no done", reg_rdata[3], 0);
      reg_write(32'h11); mem_write(16'h0);
      reg_write(32'h11); mem_write(16'h0);
      chk("R10", "refs alone no done", reg_rdata[3], 0);
      reg_write(32'h14); mem_write(16'h0442);
      chk("R10", "later mrs sets done", c_done2, 1);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_disabled();
      t_pall();
      t_ref();
      t_mrs_map();
      t_priority_ready();
      t_once();
      t_order1();
      t_order2();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule